// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card bus clock from a source clock. A four-way mode field picks the clocking scheme: divided single rate, straight pass-through of the source, divided double rate, and a high-speed mode that runs at half the source rate. A divider field scales the clock in the divided modes. The code zero in that field has its own meaning, and that meaning depends on the mode.

The configuration fields are presented as levels. They are captured into the block only on a one-cycle load strobe. Each load restarts the divider and drops a stable flag. The flag rises again once the new setting has produced the start of a fresh output period. Software clears the clock enable around a reconfiguration and waits for the stable flag before setting the enable again. While the enable is low, the card clock is held low.

All divided waveforms are made by registers clocked by the source, so they change only on source rising edges. The pass-through path uses an enable that is updated on the source falling edge, so switching it on or off cannot cut a pulse short. A parameter sets the divider width to 8 or 12 bits. A wider input value saturates at the largest divider.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the captured setting is mode 0 with divider 0 (source/2), the card clock is low, the DDR indicator is 0 and the stable flag is 0.
- R2: In mode 0 (divided single rate), a divider of 0 gives source/2 and a divider N>0 gives source/(4N). The output is high for exactly half of each period and starts low after a load.
- R3: In mode 1 (pass-through), the card clock equals the source clock while the enable is set. The enable is sampled on the source falling edge.
- R4: In mode 2 (divided double rate), a divider of 0 gives source/4 and N>0 gives source/(4N). The DDR indicator is 1 exactly while the captured mode is 2 or 3.
- R5: In mode 3 with the half-rate bit set, the output is source/2 whatever the divider. In mode 3 with the bit clear, the output behaves as in mode 2. In modes 0 to 2 the half-rate bit has no effect.
- R6: A divider input above 2^DIV_BITS-1 acts as 2^DIV_BITS-1.
- R7: Mode, divider and half-rate inputs take effect only in the cycle the load strobe is high. Changing them without a load leaves the card clock and the DDR indicator unchanged.
- R8: The stable flag is 0 after every load edge and stays 0 for at least two source edges. In divided modes it rises on the edge that begins the first new high phase at least two edges after the load. In pass-through it rises two edges after the load. Once high, it stays high until the next load.
- R9: While the clock enable is 0, the card clock is low in every mode. In divided modes the enable is sampled on each source rising edge.
- R10: In divided modes the card clock changes only on source rising edges and holds its level through the low half of the source period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that captures mode, divider and half-rate bit |
| cfg_mode | input | 2 | 0 divided, 1 pass-through, 2 divided DDR, 3 high-speed |
| cfg_div | input | DIV_IN_W | Divider code, saturated to DIV_BITS bits |
| cfg_half | input | 1 | Half-rate enable, used only in mode 3 |
| cfg_clk_en | input | 1 | Card clock enable |
| card_clk | output | 1 | Card bus clock |
| ddr_mode | output | 1 | High while the captured mode is a double-rate mode |
| clk_stable | output | 1 | High once the captured setting has settled |

## Verification
The bench goes after the mode-dependent meaning of divider zero. A design that decodes zero the same way in every mode produces /4 instead of /2 in mode 0, or /2 instead of /4 in mode 2. It also checks that the half-rate bit is honoured only in mode 3 and that an oversized divider saturates. If this were wrong, the mode-0 period would shrink, or a wrapped divider would give a far faster clock. Changes to the fields without a load strobe must leave the clock alone, and a design that decodes the live inputs fails this at once. The stable flag is checked on every cycle around back-to-back loads and ratio-2 settings. A flag that rises too early reports a setting as settled before its first full period. The pass-through mode is sampled in both source phases, and the enable is toggled mid-run, which catches a truncated pulse or a clock that leaks while disabled.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
   typedef enum logic [1:0] {
      CKM_DIV  = 2'd0,
      CKM_BYP  = 2'd1,
      CKM_DDR  = 2'd2,
      CKM_HALF = 2'd3
   } ckm_e;
endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg #(
   parameter int DIV_IN_W = 12,
   parameter int DIV_BITS = 8
) (
   input  logic                  clk_src,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [1:0]            mode_i,
   input  logic [DIV_IN_W-1:0]   div_i,
   input  logic                  half_i,
   output sdclk_pkg::ckm_e       mode_q,
   output logic [DIV_BITS-1:0]   div_q,
   output logic                  half_q
);
   logic [DIV_BITS-1:0] div_sat;

   generate
      if (DIV_IN_W > DIV_BITS) begin : g_sat
         localparam logic [DIV_IN_W-1:0] LIM =
            {{(DIV_IN_W-DIV_BITS){1'b0}}, {DIV_BITS{1'b1}}};
         assign div_sat = (div_i > LIM) ? {DIV_BITS{1'b1}} : div_i[DIV_BITS-1:0];
      end else begin : g_pass
         assign div_sat = div_i[DIV_BITS-1:0];
      end
   endgenerate

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= sdclk_pkg::CKM_DIV;
         div_q  <= '0;
         half_q <= 1'b0;
      end else if (load_i) begin
         mode_q <= sdclk_pkg::ckm_e'(mode_i);
         div_q  <= div_sat;
         half_q <= half_i;
      end
   end
endmodule

// File: rtl/sdclk_ratio.sv
module sdclk_ratio #(
   parameter int DIV_BITS = 8,
   localparam int CNT_W   = DIV_BITS + 1
) (
   input  sdclk_pkg::ckm_e      mode_i,
   input  logic [DIV_BITS-1:0]  div_i,
   input  logic                 half_i,
   output logic [CNT_W-1:0]     half_m1_o,
   output logic                 bypass_o
);
   logic [CNT_W-1:0] half_len;

   always_comb begin
      bypass_o = (mode_i == sdclk_pkg::CKM_BYP);
      if (mode_i == sdclk_pkg::CKM_HALF && half_i)
         half_len = CNT_W'(1);
      else if (div_i == '0)
         half_len = (mode_i == sdclk_pkg::CKM_DIV) ? CNT_W'(1) : CNT_W'(2);
      else
         half_len = {div_i, 1'b0};
      half_m1_o = half_len - CNT_W'(1);
   end
endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase #(
   parameter int CNT_W = 9
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] half_m1_i,
   input  logic             bypass_i,
   input  logic             en_i,
   output logic             clk_o,
   output logic             rise_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             ph_q;
   logic             wrap;
   logic             ph_nxt;

   assign wrap   = (cnt_q == half_m1_i);
   assign ph_nxt = wrap ? ~ph_q : ph_q;
   assign rise_o = wrap && !ph_q;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_q  <= 1'b0;
         clk_o <= 1'b0;
      end else if (restart_i) begin
         cnt_q <= '0;
         ph_q  <= 1'b0;
         clk_o <= 1'b0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
         ph_q  <= ph_nxt;
         clk_o <= en_i && !bypass_i && ph_nxt;
      end
   end
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle (
   input  logic clk_src,
   input  logic rst_n,
   input  logic restart_i,
   input  logic bypass_i,
   input  logic rise_i,
   output logic stable_o
);
   logic [1:0] age_q;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         age_q    <= '0;
         stable_o <= 1'b0;
      end else if (restart_i) begin
         age_q    <= '0;
         stable_o <= 1'b0;
      end else begin
         if (age_q != 2'd3) age_q <= age_q + 2'd1;
         if (!stable_o && age_q != 2'd0 && (bypass_i || rise_i))
            stable_o <= 1'b1;
      end
   end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
   parameter int DIV_IN_W = 12,
   parameter int DIV_BITS = 8
) (
   input  logic                clk_src,
   input  logic                rst_n,
   input  logic                cfg_load,
   input  logic [1:0]          cfg_mode,
   input  logic [DIV_IN_W-1:0] cfg_div,
   input  logic                cfg_half,
   input  logic                cfg_clk_en,
   output logic                card_clk,
   output logic                ddr_mode,
   output logic                clk_stable
);
   localparam int CNT_W = DIV_BITS + 1;

   generate
      if (DIV_BITS != 8 && DIV_BITS != 12) begin : g_bad_bits
         $error("sdclk_gen: DIV_BITS must be 8 or 12");
      end
      if (DIV_IN_W < DIV_BITS) begin : g_bad_in
         $error("sdclk_gen: DIV_IN_W must not be below DIV_BITS");
      end
   endgenerate

   sdclk_pkg::ckm_e     mode_q;
   logic [DIV_BITS-1:0] div_q;
   logic                half_q;
   logic [CNT_W-1:0]    half_m1;
   logic                bypass;
   logic                div_clk_q;
   logic                rise_evt;
   logic                byp_gate_q;

   sdclk_cfg #(.DIV_IN_W(DIV_IN_W), .DIV_BITS(DIV_BITS)) u_cfg (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .load_i  (cfg_load),
      .mode_i  (cfg_mode),
      .div_i   (cfg_div),
      .half_i  (cfg_half),
      .mode_q  (mode_q),
      .div_q   (div_q),
      .half_q  (half_q)
   );

   sdclk_ratio #(.DIV_BITS(DIV_BITS)) u_ratio (
      .mode_i    (mode_q),
      .div_i     (div_q),
      .half_i    (half_q),
      .half_m1_o (half_m1),
      .bypass_o  (bypass)
   );

   sdclk_phase #(.CNT_W(CNT_W)) u_phase (
      .clk_src   (clk_src),
      .rst_n     (rst_n),
      .restart_i (cfg_load),
      .half_m1_i (half_m1),
      .bypass_i  (bypass),
      .en_i      (cfg_clk_en),
      .clk_o     (div_clk_q),
      .rise_o    (rise_evt)
   );

   sdclk_settle u_settle (
      .clk_src   (clk_src),
      .rst_n     (rst_n),
      .restart_i (cfg_load),
      .bypass_i  (bypass),
      .rise_i    (rise_evt),
      .stable_o  (clk_stable)
   );

   // pass-through enable moves only while the source is low
   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n) byp_gate_q <= 1'b0;
      else        byp_gate_q <= bypass && cfg_clk_en;
   end

   assign card_clk = (clk_src && byp_gate_q) || div_clk_q;
   assign ddr_mode = mode_q[1];
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk (
   input logic clk_src,
   input logic rst_n,
   input logic cfg_load,
   input logic cfg_clk_en,
   input logic div_clk,
   input logic byp_gate,
   input logic ddr_mode,
   input logic clk_stable
);
   p_load_drops_stable_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
      cfg_load |=> (!clk_stable ##1 !clk_stable));

   p_stable_holds_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
      (clk_stable && !cfg_load) |=> clk_stable);

   p_ddr_needs_load_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
      !cfg_load |=> $stable(ddr_mode));

   p_idle_when_off_r9: assert property (@(posedge clk_src) disable iff (!rst_n)
      !cfg_clk_en |=> !div_clk);

   p_paths_exclusive_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
      !(byp_gate && div_clk));

   p_load_restarts_low_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
      cfg_load |=> !div_clk);
endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
   .clk_src    (clk_src),
   .rst_n      (rst_n),
   .cfg_load   (cfg_load),
   .cfg_clk_en (cfg_clk_en),
   .div_clk    (div_clk_q),
   .byp_gate   (byp_gate_q),
   .ddr_mode   (ddr_mode),
   .clk_stable (clk_stable)
);

// File: tb/sdclk_gen_test.sv
`timescale 1ns/100ps
module sdclk_gen_test;
   localparam int DIV_IN_W = 12;
   localparam int DIV_BITS = 8;
   localparam int DMAX     = (1 << DIV_BITS) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [DIV_IN_W-1:0] cfg_div = '0;
   logic cfg_half = 1'b0;
   logic cfg_clk_en = 1'b0;
   logic card_clk, ddr_mode, clk_stable;

   always #2 clk = ~clk;

   sdclk_gen #(.DIV_IN_W(DIV_IN_W), .DIV_BITS(DIV_BITS)) uut (
      .clk_src(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
      .cfg_div(cfg_div), .cfg_half(cfg_half), .cfg_clk_en(cfg_clk_en),
      .card_clk(card_clk), .ddr_mode(ddr_mode), .clk_stable(clk_stable)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   string cur_req = "R1";

   // reference model state
   int m_mode = 0, m_n = 0, m_half = 0, m_k = 0;
   bit m_stable = 0, exp_cko = 0, exp_byp = 0, byp_pend = 0;

   function automatic int half_len();
      if (m_mode == 3 && m_half != 0) return 1;
      if (m_n == 0) return (m_mode == 0) ? 1 : 2;
      return 2 * m_n;
   endfunction

   task automatic cmp(input string req, input logic act, input logic expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, expv);
      end
   endtask

   always @(posedge clk) begin
      exp_byp = byp_pend;
      if (!rst_n) begin
         m_mode = 0; m_n = 0; m_half = 0; m_k = 0; m_stable = 0; exp_cko = 0;
      end else if (cfg_load) begin
         m_mode = cfg_mode;
         m_n = (int'(cfg_div) > DMAX) ? DMAX : int'(cfg_div);
         m_half = cfg_half; m_k = 0; m_stable = 0; exp_cko = 0;
      end else begin
         m_k++;
         if (m_mode == 1) exp_cko = 0;
         else exp_cko = cfg_clk_en && (((m_k / half_len()) % 2) == 1);
         if (!m_stable && m_k >= 2 &&
             (m_mode == 1 || (m_k % (2 * half_len())) == half_len()))
            m_stable = 1;
      end
      byp_pend = rst_n && (m_mode == 1) && cfg_clk_en;
      #1;
      cmp(cur_req, card_clk, exp_byp | exp_cko);
      cmp("R8 stable", clk_stable, m_stable);
      cmp("R4 ddr", ddr_mode, m_mode >= 2);
      #1.5;
      cmp("R10 low half", card_clk, exp_cko);
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #3.5;
   endtask

   task automatic reconf(input int md, input int dv, input bit hf, input int n);
      cfg_clk_en = 1'b0;
      step(1);
      cfg_mode = md[1:0]; cfg_div = dv[DIV_IN_W-1:0]; cfg_half = hf; cfg_load = 1'b1;
      step(1);
      cfg_load = 1'b0;
      step(1);
      cfg_clk_en = 1'b1;
      step(n);
   endtask

   initial begin
      // R1: reset state
      #1;
      cmp("R1 card", card_clk, 1'b0);
      cmp("R1 stable", clk_stable, 1'b0);
      cmp("R1 ddr", ddr_mode, 1'b0);
      step(4);
      rst_n = 1'b1;
      step(10);
      cfg_clk_en = 1'b1;
      cur_req = "R2"; step(20);                 // mode 0, divider 0: /2
      reconf(0, 3, 0, 60);                      // /12
      reconf(0, 1, 0, 30);                      // /4
      cur_req = "R3"; reconf(1, 7, 0, 20);      // pass-through
      cur_req = "R9"; cfg_clk_en = 1'b0; step(6); cfg_clk_en = 1'b1; step(6);
      cur_req = "R4"; reconf(2, 0, 0, 30);      // /4
      reconf(2, 2, 0, 40);                      // /8
      cur_req = "R5"; reconf(3, 5, 1, 20);      // half-rate /2
      reconf(3, 0, 0, 30);                      // mode 3 without bit: /4
      reconf(0, 2, 1, 40);                      // bit ignored in mode 0: /8
      reconf(2, 0, 1, 30);                      // bit ignored in mode 2: /4
      cur_req = "R7";                           // fields change, no load
      cfg_mode = 2'd1; cfg_div = 12'd9; cfg_half = 1'b1; step(40);
      cur_req = "R9"; cfg_clk_en = 1'b0; step(9); cfg_clk_en = 1'b1; step(11);
      cur_req = "R8";                           // back-to-back loads
      cfg_mode = 2'd0; cfg_div = 12'd0; cfg_load = 1'b1; step(1);
      cfg_mode = 2'd2; cfg_div = 12'd1; step(1);
      cfg_load = 1'b0; step(20);
      reconf(0, 0, 0, 10);
      cur_req = "R6"; reconf(0, 300, 0, 2200);  // saturates to 255: /1020
      step(2);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule